// File: doc/BRIEF.md
# Serial-Addressed Multi-Channel Register Bank

This block is the digital side of a twelve-channel trim converter. A host shifts short frames into it over a three-wire serial port: a serial clock, an active-low select and a data line. Each frame holds a channel number and an 8-bit setting. When the select line is released, the block writes that setting into the matching holding register. The twelve holding registers drive parallel outputs that feed the analog dividers.

All three serial lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the block detects edges on the synchronized copies. A preset input forces every channel to midscale. A shutdown input raises a power-down flag and leaves the stored settings alone, so they are in force again as soon as shutdown is removed.

Top module: `trim_reg_bank`

## Requirements
- R1: After rst_ni is asserted, every channel output reads 0x00 and pwrdn_o is 0.
- R2: A frame has 12 bits, sampled on rising serial-clock edges: a 4-bit channel number MSB first, then an 8-bit value MSB first. Channel number n writes chan_o bits [8n+7:8n], so channel number 0 is the lowest byte.
- R3: The addressed register changes only after csn_i rises. Until then, every output keeps its previous value, even when 12 bits have already arrived.
- R4: When more than 12 bits arrive in one select window, only the last 12 bits form the frame.
- R5: When fewer than 12 bits arrive before csn_i rises, the frame is discarded and no output changes.
- R6: A frame whose channel number is 12 to 15 changes no output.
- R7: Serial-clock edges while csn_i is high are ignored. Every window starts a fresh bit count.
- R8: While preset_i is high, every channel reads 0x80.
- R9: A frame that completes while preset_i is high leaves every channel at 0x80.
- R10: shdn_i drives pwrdn_o high within four system clocks. Stored values stay unchanged during shutdown and after it is released.
- R11: A write to one channel leaves the other eleven unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Serial select, active low, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| preset_i | input | 1 | Forces all channels to midscale while high |
| shdn_i | input | 1 | Shutdown request |
| chan_o | output | 96 | Twelve 8-bit channel values, channel 0 in bits [7:0] |
| pwrdn_o | output | 1 | Power-down flag |

## Verification
A bad bit count or a stale shift register shows up as a wrong byte, or as a byte on the wrong channel, once the select line has been high for about five system clocks. A write strobe that fires during the frame shows up as an output that changes before csn_i rises. The bench compares all twelve channels against a model after every stimulus, so a stray write to an unaddressed channel is caught at the same point.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int unsigned NCH = 12;
  localparam int unsigned AW  = 4;
  localparam int unsigned DW  = 8;
  localparam logic [DW-1:0] MID = 8'h80;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/trim_rx.sv
module trim_rx #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8,
  localparam int unsigned FRM = AW + DW,
  localparam int unsigned CW  = $clog2(FRM + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_s_i,
  input  logic          csn_s_i,
  input  logic          sdi_s_i,
  output logic          stb_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic           sclk_q, csn_q;
  logic [FRM-1:0] shreg_q;
  logic [CW-1:0]  cnt_q;
  logic           sclk_rise, cs_fall, cs_rise;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign cs_fall   = ~csn_s_i & csn_q;
  assign cs_rise   = csn_s_i & ~csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
      stb_o   <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      csn_q  <= csn_s_i;
      stb_o  <= cs_rise && (cnt_q == CW'(FRM));
      if (cs_fall) begin
        cnt_q <= '0;
      end else if (!csn_s_i && sclk_rise) begin
        // Oldest bits fall off the top; the count saturates at the frame length.
        shreg_q <= {shreg_q[FRM-2:0], sdi_s_i};
        if (cnt_q != CW'(FRM)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign addr_o = shreg_q[FRM-1 -: AW];
  assign data_o = shreg_q[DW-1:0];
endmodule

// File: rtl/trim_regs.sv
module trim_regs #(
  parameter int unsigned NCH = 12,
  parameter int unsigned AW  = 4,
  parameter int unsigned DW  = 8,
  parameter logic [DW-1:0] MID = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              preset_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [NCH*DW-1:0] chan_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] val_q;
    logic          hit;

    assign hit = wr_i && (addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      val_q <= '0;
      else if (preset_i) val_q <= MID;
      else if (hit)      val_q <= data_i;
    end

    assign chan_o[g*DW +: DW] = val_q;
  end
endmodule

// File: rtl/trim_reg_bank.sv
module trim_reg_bank
  import trim_pkg::*;
#(
  parameter int unsigned NUM_CH   = NCH,
  parameter int unsigned ADDR_W   = AW,
  parameter int unsigned DATA_W   = DW,
  parameter logic [DATA_W-1:0] MID_VAL = MID
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     csn_i,
  input  logic                     sdi_i,
  input  logic                     preset_i,
  input  logic                     shdn_i,
  output logic [NUM_CH*DATA_W-1:0] chan_o,
  output logic                     pwrdn_o
);
  logic [4:0]        sync_s;
  logic              preset_s;
  logic              frm_stb;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data;

  trim_sync #(.WIDTH(5), .RST_VAL(5'b00010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({preset_i, shdn_i, sdi_i, csn_i, sclk_i}),
    .q_o    (sync_s)
  );

  assign preset_s = sync_s[4];
  assign pwrdn_o  = sync_s[3];

  trim_rx #(.AW(ADDR_W), .DW(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (sync_s[0]),
    .csn_s_i  (sync_s[1]),
    .sdi_s_i  (sync_s[2]),
    .stb_o    (frm_stb),
    .addr_o   (frm_addr),
    .data_o   (frm_data)
  );

  trim_regs #(.NCH(NUM_CH), .AW(ADDR_W), .DW(DATA_W), .MID(MID_VAL)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (preset_s),
    .wr_i     (frm_stb),
    .addr_i   (frm_addr),
    .data_i   (frm_data),
    .chan_o   (chan_o)
  );
endmodule

// File: rtl/trim_reg_bank_chk.sv
module trim_reg_bank_chk #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] MID_VAL = 8'h80
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CH*DATA_W-1:0] chan_i,
  input logic                     pre_i,
  input logic                     stb_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [DATA_W-1:0]        data_i
);
  AST_PRESET_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> (chan_i == {NUM_CH{MID_VAL}})); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_i && !pre_i) |=> $stable(chan_i)); // R3

  AST_BAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !pre_i && (int'(addr_i) >= NUM_CH)) |=> $stable(chan_i)); // R6

  AST_WRITE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !pre_i && (int'(addr_i) < NUM_CH))
      |=> (chan_i[int'($past(addr_i))*DATA_W +: DATA_W] == $past(data_i))); // R2

  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> !stb_i); // R5
endmodule

bind trim_reg_bank trim_reg_bank_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_VAL(MID_VAL)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .chan_i (chan_o),
  .pre_i  (preset_s),
  .stb_i  (frm_stb),
  .addr_i (frm_addr),
  .data_i (frm_data)
);

// File: tb/sim_trim_reg_bank.sv
module sim_trim_reg_bank;
  localparam int NCHAN = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, preset = 1'b0, shdn = 1'b0;
  logic [NCHAN*8-1:0] chan;
  logic pwrdn;
  logic [7:0] exp_q [NCHAN];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trim_reg_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .preset_i(preset), .shdn_i(shdn), .chan_o(chan), .pwrdn_o(pwrdn)
  );

  // {addr, data} vectors
  localparam logic [11:0] VEC [8] = '{12'h03C, 12'hBA5, 12'h5FF, 12'h700,
                                      12'h112, 12'hA5A, 12'h3C3, 12'h0E1};

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    csn = 1'b0;
    wait_clk(4);
    shift_bits(v, n);
    wait_clk(4);
    csn = 1'b1;
    wait_clk(10);
  endtask

  task automatic check_all(input string req);
    int bad = -1;
    checks++;
    for (int i = 0; i < NCHAN; i++)
      if (bad < 0 && chan[i*8 +: 8] !== exp_q[i]) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: channel %0d actual %02h expected %02h",
               req, bad, chan[bad*8 +: 8], exp_q[bad]);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCHAN; i++) exp_q[i] = 8'h00;
    wait_clk(3);
    // R1 reset state
    check_all("R1");
    check_bit("R1", pwrdn, 1'b0);
    rst_n = 1'b1;
    wait_clk(3);

    // R2 / R11 vector walk
    for (int k = 0; k < 8; k++) begin
      frame({20'h0, VEC[k]}, 12);
      exp_q[VEC[k][11:8]] = VEC[k][7:0];
      check_all("R2/R11");
    end

    // R3 no update before select rises
    csn = 1'b0;
    wait_clk(4);
    shift_bits(32'h266, 12);
    wait_clk(12);
    check_all("R3");
    csn = 1'b1;
    wait_clk(10);
    exp_q[2] = 8'h66;
    check_all("R3");

    // R4 oversize frame: last 12 bits count
    frame(32'hF4_9D, 16);
    exp_q[4] = 8'h9D;
    check_all("R4");

    // R5 short frame discarded
    frame(32'h1F, 8);
    check_all("R5");
    frame(32'h8AA, 11);
    check_all("R5");

    // R6 channel numbers 12..15
    frame(32'hC55, 12);
    check_all("R6");
    frame(32'hF77, 12);
    check_all("R6");

    // R7 clock edges with select high, then a fresh short window
    sdi = 1'b1;
    for (int i = 0; i < 12; i++) begin
      sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
    end
    wait_clk(10);
    check_all("R7");
    frame(32'h9, 4);
    check_all("R7");

    // R10 shutdown keeps values
    shdn = 1'b1;
    wait_clk(4);
    check_bit("R10", pwrdn, 1'b1);
    check_all("R10");
    shdn = 1'b0;
    wait_clk(4);
    check_bit("R10", pwrdn, 1'b0);
    check_all("R10");

    // R8 preset
    preset = 1'b1;
    wait_clk(4);
    for (int i = 0; i < NCHAN; i++) exp_q[i] = 8'h80;
    check_all("R8");

    // R9 frame completing under preset
    frame(32'h611, 12);
    check_all("R9");
    preset = 1'b0;
    wait_clk(4);
    check_all("R9");
    frame(32'h622, 12);
    exp_q[6] = 8'h22;
    check_all("R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule